// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds eight one-bit semaphore latches that two agents, a left port and a right port, use to claim and release shared resources. The latches sit apart from any memory. A port reaches them by pulling its semaphore select low while its memory chip enable stays high. It picks a semaphore through the three low bits of its address, and it either writes one data bit or reads the result. Writing 0 asks for a semaphore and writing 1 gives it up, or withdraws a request that is still waiting.

Each semaphore tracks a request flag per side and a single owner. A port reads 0 while it owns the semaphore and 1 at all other times. A request made while the other side owns the semaphore waits. When the owner lets go, ownership passes to the waiting side on that same clock edge. Reads are registered: the chosen semaphore's value is copied onto all eight read-data bits. That value then holds until the same port reads again, so a write from the other side cannot disturb a result that has already been returned.

Top module: `sem_bank_2p`

## Requirements
- R1: After reset all eight semaphores are free, and both read buses show 8'hFF.
- R2: The semaphore index is taken from address bits [2:0]. Address bits above bit 2 have no effect on which semaphore is written or read.
- R3: An access counts only when sem_ni=0 and ce_ni=1. With sem_ni=0 and ce_ni=0 (the illegal combination), no semaphore changes and the port's read bus keeps its value.
- R4: A write (we_i=1) uses only wdata_i. The value 0 requests the semaphore and the value 1 releases it, or cancels a waiting request.
- R5: A request on a free semaphore grants it on the same edge. The requesting port then reads 8'h00 at that index and the other port reads 8'hFF.
- R6: A request from the side that does not own the semaphore leaves the owner unchanged and is held pending.
- R7: When the owner writes 1 and the other side has a pending request, the other side becomes owner on that edge. With nothing pending, both sides read 8'hFF.
- R8: A non-owner that writes 1 withdraws its pending request, so a later release by the owner leaves the semaphore free.
- R9: A read (we_i=0) loads the port's read register on the next edge, with the value replicated on all 8 bits (8'h00 = owned by this port, 8'hFF = not). The register holds its value through cycles with no read.
- R10: A read captures the semaphore state from before any write the other port makes on the same edge.
- R11: If both ports request the same free semaphore on the same edge, the left port obtains it and the right port's request stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_sem_ni | input | 1 | Left semaphore select, active low |
| l_ce_ni | input | 1 | Left memory chip enable, active low, must be high for semaphore access |
| l_addr_i | input | 13 | Left address, low 3 bits pick the semaphore |
| l_we_i | input | 1 | Left write strobe (0 = read) |
| l_wdata_i | input | 1 | Left write bit (0 request, 1 release) |
| l_rdata_o | output | 8 | Left registered read data |
| r_sem_ni | input | 1 | Right semaphore select, active low |
| r_ce_ni | input | 1 | Right memory chip enable, active low |
| r_addr_i | input | 13 | Right address |
| r_we_i | input | 1 | Right write strobe |
| r_wdata_i | input | 1 | Right write bit |
| r_rdata_o | output | 8 | Right registered read data |

## Verification
The bench targets the handoff from an owner to a waiting side. A design without a stored request would free the semaphore instead, and the waiting side would read FF. It also drives a same-edge tie on a free semaphore, where a faulty arbiter would grant both sides or neither. It checks that a withdrawn request is not granted later on. Finally it reads on the same edge that the other port releases, which shows whether the read register really samples the old state, and it uses the illegal enable combination and high address bits to catch decoding that lets stray accesses through.

// File: rtl/sem_bank_pkg.sv
package sem_bank_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
  parameter int ADDR_W = 13,
  parameter int N_SEM  = 8,
  localparam int IDX_W = $clog2(N_SEM)
) (
  input  logic              sem_ni,
  input  logic              ce_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              wdata_i,
  output logic [N_SEM-1:0]  set_o,
  output logic [N_SEM-1:0]  clr_o,
  output logic              rd_o,
  output logic [IDX_W-1:0]  rd_idx_o
);
  logic             sel;
  logic [IDX_W-1:0] idx;
  logic             unused_addr;

  assign sel         = !sem_ni && ce_ni;
  assign idx         = addr_i[IDX_W-1:0];
  assign unused_addr = ^addr_i[ADDR_W-1:IDX_W];
  assign rd_o        = sel && !we_i;
  assign rd_idx_o    = idx;

  always_comb begin
    for (int i = 0; i < N_SEM; i++) begin
      set_o[i] = sel && we_i && !wdata_i && (idx == IDX_W'(i));
      clr_o[i] = sel && we_i &&  wdata_i && (idx == IDX_W'(i));
    end
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_bank_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_l_i,
  input  logic clr_l_i,
  input  logic set_r_i,
  input  logic clr_r_i,
  output logic own_l_o,
  output logic own_r_o
);
  owner_e owner_q, owner_d;
  logic   req_l_q, req_r_q, req_l_d, req_r_d;

  assign req_l_d = set_l_i ? 1'b1 : (clr_l_i ? 1'b0 : req_l_q);
  assign req_r_d = set_r_i ? 1'b1 : (clr_r_i ? 1'b0 : req_r_q);

  // left takes a free semaphore on a tie
  always_comb begin
    owner_d = owner_q;
    unique case (owner_q)
      OWN_NONE: begin
        if (req_l_d)      owner_d = OWN_LEFT;
        else if (req_r_d) owner_d = OWN_RIGHT;
      end
      OWN_LEFT:  if (!req_l_d) owner_d = req_r_d ? OWN_RIGHT : OWN_NONE;
      OWN_RIGHT: if (!req_r_d) owner_d = req_l_d ? OWN_LEFT : OWN_NONE;
      default:   owner_d = OWN_NONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q <= OWN_NONE;
      req_l_q <= 1'b0;
      req_r_q <= 1'b0;
    end else begin
      owner_q <= owner_d;
      req_l_q <= req_l_d;
      req_r_q <= req_r_d;
    end
  end

  assign own_l_o = (owner_q == OWN_LEFT);
  assign own_r_o = (owner_q == OWN_RIGHT);

  assert_grant_free_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_NONE && set_l_i) |=> own_l_o);
  assert_keep_left_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_LEFT && !clr_l_i) |=> own_l_o);
  assert_keep_right_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_RIGHT && !clr_r_i) |=> own_r_o);
  assert_handoff_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_LEFT && clr_l_i && req_r_q && !clr_r_i) |=> own_r_o);
  assert_cancel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_LEFT && clr_r_i) |=> !req_r_q);
  assert_tie_left_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_NONE && set_l_i && set_r_i) |=> (own_l_o && req_r_q));
endmodule

// File: rtl/sem_rd_reg.sv
module sem_rd_reg #(
  parameter int N_SEM  = 8,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(N_SEM)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [N_SEM-1:0]  own_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '1;
    else if (rd_i) rdata_o <= {DATA_W{!own_i[idx_i]}};
  end

  assert_replicate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o == '0) || (rdata_o == '1));
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/sem_bank_2p.sv
module sem_bank_2p #(
  parameter int ADDR_W = 13,
  parameter int N_SEM  = 8,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(N_SEM)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_sem_ni,
  input  logic              l_ce_ni,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic              l_we_i,
  input  logic              l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  input  logic              r_sem_ni,
  input  logic              r_ce_ni,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic              r_we_i,
  input  logic              r_wdata_i,
  output logic [DATA_W-1:0] r_rdata_o
);
  logic [N_SEM-1:0] l_set, l_clr, r_set, r_clr, own_l, own_r;
  logic             l_rd, r_rd;
  logic [IDX_W-1:0] l_idx, r_idx;

  sem_port_dec #(.ADDR_W(ADDR_W), .N_SEM(N_SEM)) u_dec_l (
    .sem_ni(l_sem_ni), .ce_ni(l_ce_ni), .addr_i(l_addr_i), .we_i(l_we_i),
    .wdata_i(l_wdata_i), .set_o(l_set), .clr_o(l_clr), .rd_o(l_rd), .rd_idx_o(l_idx));

  sem_port_dec #(.ADDR_W(ADDR_W), .N_SEM(N_SEM)) u_dec_r (
    .sem_ni(r_sem_ni), .ce_ni(r_ce_ni), .addr_i(r_addr_i), .we_i(r_we_i),
    .wdata_i(r_wdata_i), .set_o(r_set), .clr_o(r_clr), .rd_o(r_rd), .rd_idx_o(r_idx));

  for (genvar g = 0; g < N_SEM; g++) begin : g_cell
    sem_cell u_cell (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .set_l_i(l_set[g]), .clr_l_i(l_clr[g]),
      .set_r_i(r_set[g]), .clr_r_i(r_clr[g]),
      .own_l_o(own_l[g]), .own_r_o(own_r[g]));
  end

  sem_rd_reg #(.N_SEM(N_SEM), .DATA_W(DATA_W)) u_rd_l (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(l_rd), .idx_i(l_idx),
    .own_i(own_l), .rdata_o(l_rdata_o));

  sem_rd_reg #(.N_SEM(N_SEM), .DATA_W(DATA_W)) u_rd_r (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(r_rd), .idx_i(r_idx),
    .own_i(own_r), .rdata_o(r_rdata_o));

  assert_illegal_l_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_sem_ni && !l_ce_ni) |=> ($stable(l_rdata_o) && $stable(own_l)));
  assert_illegal_r_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!r_sem_ni && !r_ce_ni) |=> ($stable(r_rdata_o) && $stable(own_r)));
  assert_single_owner_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_l & own_r) == '0);
endmodule

// File: tb/sim_sem_bank_2p.sv
module sim_sem_bank_2p;
  localparam int ADDR_W = 13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic l_sem_n, l_ce_n, l_we, l_wd, r_sem_n, r_ce_n, r_we, r_wd;
  logic [ADDR_W-1:0] l_addr, r_addr;
  logic [7:0] l_rdata, r_rdata;

  int checks = 0, fails = 0, cyc = 0;

  typedef struct {
    int         due;
    bit         right;
    logic [7:0] exp;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sem_bank_2p #(.ADDR_W(ADDR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .l_sem_ni(l_sem_n), .l_ce_ni(l_ce_n), .l_addr_i(l_addr), .l_we_i(l_we),
    .l_wdata_i(l_wd), .l_rdata_o(l_rdata),
    .r_sem_ni(r_sem_n), .r_ce_ni(r_ce_n), .r_addr_i(r_addr), .r_we_i(r_we),
    .r_wdata_i(r_wd), .r_rdata_o(r_rdata));

  // monitor: compare queued expectations once their edge has passed
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      logic [7:0] act;
      e = sb.pop_front();
      act = e.right ? r_rdata : l_rdata;
      checks++;
      if (act !== e.exp) begin
        fails++;
        $display("FAIL %s %s port: got %h expected %h", e.tag, e.right ? "right" : "left", act, e.exp);
      end
    end
  end

  // op: 0 idle, 1 write, 2 read, 3 illegal write, 4 illegal read
  task automatic drive(bit right, int op, logic [ADDR_W-1:0] a, logic d);
    logic sn, cn, we;
    sn = (op == 0); cn = !(op == 3 || op == 4); we = (op == 1 || op == 3);
    if (right) begin r_sem_n = sn; r_ce_n = cn; r_addr = a; r_we = we; r_wd = d; end
    else       begin l_sem_n = sn; l_ce_n = cn; l_addr = a; l_we = we; l_wd = d; end
  endtask

  task automatic expect_rd(bit right, logic [7:0] v, string tag);
    exp_t e;
    e.due = cyc + 1; e.right = right; e.exp = v; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic tick();
    @(negedge clk);
    drive(0, 0, '0, 1'b1);
    drive(1, 0, '0, 1'b1);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    drive(0, 0, '0, 1'b1);
    drive(1, 0, '0, 1'b1);
    repeat (2) @(negedge clk);
    // R1: reset value
    checks += 2;
    if (l_rdata !== 8'hFF) begin fails++; $display("FAIL R1 left: got %h expected ff", l_rdata); end
    if (r_rdata !== 8'hFF) begin fails++; $display("FAIL R1 right: got %h expected ff", r_rdata); end
    rst_n = 1'b1;
    tick();

    // R4/R5: left requests sem 3 through an address with high bits set
    drive(0, 1, 13'h0A53, 1'b0); tick();
    drive(0, 2, 13'h0003, 1'b0); expect_rd(0, 8'h00, "R5");
    drive(1, 2, 13'h1F03, 1'b0); expect_rd(1, 8'hFF, "R5"); tick();
    // R2: different index unaffected; high bits ignored
    drive(0, 2, 13'h1FF2, 1'b0); expect_rd(0, 8'hFF, "R2");
    drive(1, 2, 13'h0403, 1'b0); expect_rd(1, 8'hFF, "R2"); tick();
    drive(0, 2, 13'h1C03, 1'b0); expect_rd(0, 8'h00, "R2"); tick();

    // R6: right request on held sem is pending
    drive(1, 1, 13'h0003, 1'b0); tick();
    drive(0, 2, 13'h0003, 1'b0); expect_rd(0, 8'h00, "R6");
    drive(1, 2, 13'h0003, 1'b0); expect_rd(1, 8'hFF, "R6"); tick();

    // R7: release hands off to pending right
    drive(0, 1, 13'h0003, 1'b1); tick();
    drive(0, 2, 13'h0003, 1'b0); expect_rd(0, 8'hFF, "R7");
    drive(1, 2, 13'h0003, 1'b0); expect_rd(1, 8'h00, "R7"); tick();
    // R4/R7: release with nothing pending frees it
    drive(1, 1, 13'h0003, 1'b1); tick();
    drive(0, 2, 13'h0003, 1'b0); expect_rd(0, 8'hFF, "R7");
    drive(1, 2, 13'h0003, 1'b0); expect_rd(1, 8'hFF, "R4"); tick();

    // R8: withdrawn request is not granted later
    drive(0, 1, 13'h0005, 1'b0); tick();
    drive(1, 1, 13'h0005, 1'b0); tick();
    drive(1, 1, 13'h0005, 1'b1); tick();
    drive(0, 1, 13'h0005, 1'b1); tick();
    drive(0, 2, 13'h0005, 1'b0); expect_rd(0, 8'hFF, "R8");
    drive(1, 2, 13'h0005, 1'b0); expect_rd(1, 8'hFF, "R8"); tick();

    // R3: illegal write ignored; right may still take sem 1
    drive(0, 3, 13'h0001, 1'b0); tick();
    drive(1, 1, 13'h0001, 1'b0); tick();
    drive(1, 2, 13'h0001, 1'b0); expect_rd(1, 8'h00, "R3"); tick();
    // R3: illegal read does not load register
    drive(0, 1, 13'h0004, 1'b0); tick();
    drive(0, 2, 13'h0000, 1'b0); expect_rd(0, 8'hFF, "R3"); tick();
    drive(0, 4, 13'h0004, 1'b0); expect_rd(0, 8'hFF, "R3"); tick();
    drive(0, 2, 13'h0004, 1'b0); expect_rd(0, 8'h00, "R3"); tick();

    // R11: tie on free sem 6 goes left, right pending
    drive(0, 1, 13'h0006, 1'b0); drive(1, 1, 13'h0006, 1'b0); tick();
    drive(0, 2, 13'h0006, 1'b0); expect_rd(0, 8'h00, "R11");
    drive(1, 2, 13'h0006, 1'b0); expect_rd(1, 8'hFF, "R11"); tick();
    drive(0, 1, 13'h0006, 1'b1); tick();
    drive(1, 2, 13'h0006, 1'b0); expect_rd(1, 8'h00, "R11"); tick();

    // R10: read on same edge as other side's release sees old state
    drive(1, 1, 13'h0004, 1'b0); tick();
    drive(0, 1, 13'h0004, 1'b1);
    drive(1, 2, 13'h0004, 1'b0); expect_rd(1, 8'hFF, "R10"); tick();
    drive(1, 2, 13'h0004, 1'b0); expect_rd(1, 8'h00, "R10"); tick();
    // R9: held without reads, even across a state change
    expect_rd(1, 8'h00, "R9"); tick();
    drive(1, 1, 13'h0004, 1'b1); expect_rd(1, 8'h00, "R9"); tick();
    expect_rd(1, 8'h00, "R9"); tick();

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule